// File: doc/BRIEF.md
# Transfer Mode Capability Selector

This block works out the fastest DMA transfer mode that a disk-style device and its host controller can both run, never faster than a mode that software asks for. It takes the capability words from the device's identify data and the host's own capability masks. It also takes a cable-type flag and two flags that can forbid DMA outright. It then searches three transfer families from the fastest family down. The first family that is allowed and has a common mode supplies the answer.

The search is combinational. The answer is captured into output registers when a compute strobe is sampled, and a one-cycle valid pulse marks the capture. Between strobes the outputs hold, so a sequencer can fire the strobe, wait one cycle and read a stable code that it then sends to the device. Sending that command is outside this block.

Top module: `xfer_mode_sel`

## Requirements
- R1: After reset, `mode` is 0x00, `no_dma` is 1 and `valid` is 0.
- R2: A `compute` sampled high at a clock edge loads the result, and `valid` is high for exactly the following cycle. Without `compute`, `valid` is 0 and `mode` and `no_dma` keep their values, whatever the inputs do.
- R3: Families are tried in the order ultra (code 0x40 + n), multiword (0x20 + n) and singleword (0x10 + n). A family is passed over when `req_mode` is below its base code or when its mask is zero. The first remaining family gives base + index of its highest set mask bit.
- R4: The ultra mask is `host_ultra_mask & id_ultra[7:0]` when `id_valid_bits[2]` is 1, and zero otherwise.
- R5: The ultra mask is cut to its bits 2:0 when all of these hold: `req_mode` > 0x42, any of mask bits 6:3 is set, and `cable80` is 0.
- R6: The multiword mask is `host_mword_mask & id_mword[7:0]` when `id_valid_bits[1]` is 1, and zero otherwise.
- R7: When `id_valid_bits[1]` is 1, the singleword mask is `host_sword_mask & id_sword[7:0]`. Otherwise, a nonzero `id_legacy_tm` whose low byte m is 2 or less gives `((2<<m)-1) & host_sword_mask`. Any other legacy word gives zero.
- R8: `mode` is the smaller of the searched code and `req_mode`. It is 0x00 when no family applies, and `no_dma` is 1 exactly when `mode` is 0x00.
- R9: When `is_disk` is 0 and `host_no_pkt_dma` is 1, the result is 0x00 with `no_dma` = 1.
- R10: When `id_valid_bits[2]` is 1 and both `id_ultra[15:8]` and `id_mword[15:8]` are nonzero, the result is 0x00 with `no_dma` = 1. The same holds when `id_valid_bits[2]` is 0, `id_valid_bits[1]` is 1, and both `id_mword[15:8]` and `id_sword[15:8]` are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| compute | input | 1 | Strobe that loads a new result |
| req_mode | input | 8 | Requested upper-limit mode code |
| id_valid_bits | input | 2 | Identify validity bits [2:1]: bit 2 enables the ultra word, bit 1 enables the multiword and singleword words |
| id_ultra | input | 16 | Device ultra word: supported modes in [7:0], selected mode in [15:8] |
| id_mword | input | 16 | Device multiword word, same layout |
| id_sword | input | 16 | Device singleword word, same layout |
| id_legacy_tm | input | 16 | Legacy singleword timing word; mode number in [7:0] |
| host_ultra_mask | input | 8 | Host ultra modes supported |
| host_mword_mask | input | 8 | Host multiword modes supported |
| host_sword_mask | input | 8 | Host singleword modes supported |
| cable80 | input | 1 | 80-conductor cable detected |
| is_disk | input | 1 | Device is a plain disk, not a packet-command device |
| host_no_pkt_dma | input | 1 | Host cannot do DMA for packet-command devices |
| mode | output | 8 | Selected transfer mode code |
| no_dma | output | 1 | No DMA mode selected |
| valid | output | 1 | One-cycle pulse after a capture |

## Verification
The output registers change only when a strobe is sampled. A fault in the search logic therefore shows up as a wrong `mode` in the cycle right after the strobe, and it stays visible until the next strobe. A gating or cap fault shows as a code from the wrong family, or as an ultra code of 0x43 to 0x46 where the cable rule forbids it. A fault in the forbid paths shows as a nonzero code with `no_dma` low. A broken hold path shows as outputs that move, or a `valid` pulse that appears, during cycles with no strobe.

// File: rtl/xms_pkg.sv
package xms_pkg;
  localparam int MASK_W = 8;
  localparam int ID_W   = 16;
  localparam int CODE_W = 8;
  localparam int FAM_N  = 3;
  localparam int IDX_W  = $clog2(MASK_W);
  localparam int SAFE_ULTRA_TOP = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MASK_W-1:0] mask_t;

  localparam code_t SW_BASE = 8'h10;
  localparam code_t MW_BASE = 8'h20;
  localparam code_t UD_BASE = 8'h40;
  localparam code_t NO_MODE = '0;

  // {hit, index of highest set bit}
  function automatic logic [IDX_W:0] top_bit(input mask_t m);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  // singleword mask from the legacy timing word
  function automatic mask_t legacy_mask(input logic [ID_W-1:0] tw, input mask_t host);
    logic [7:0] m;
    m = tw[7:0];
    if (tw != '0 && m <= 8'd2)
      return ((MASK_W'(2) << m) - MASK_W'(1)) & host;
    return '0;
  endfunction

  function automatic code_t code_min(input code_t a, input code_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/xms_family_masks.sv
module xms_family_masks
  import xms_pkg::*;
(
  input  logic [2:1]      id_valid_bits,
  input  logic [ID_W-1:0] id_ultra,
  input  logic [ID_W-1:0] id_mword,
  input  logic [ID_W-1:0] id_sword,
  input  logic [ID_W-1:0] id_legacy_tm,
  input  mask_t           host_ultra_mask,
  input  mask_t           host_mword_mask,
  input  mask_t           host_sword_mask,
  input  logic            cable80,
  input  code_t           req_mode,
  output mask_t           mask_ultra,
  output mask_t           mask_mword,
  output mask_t           mask_sword,
  output logic            cap_hit
);
  localparam code_t CAP_ABOVE = UD_BASE + code_t'(SAFE_ULTRA_TOP);
  localparam mask_t SAFE_KEEP = mask_t'((1 << (SAFE_ULTRA_TOP + 1)) - 1);
  localparam mask_t FAST_BITS = mask_t'(8'h78);

  mask_t ultra_raw;

  assign ultra_raw  = id_valid_bits[2] ? (host_ultra_mask & id_ultra[MASK_W-1:0]) : '0;
  assign cap_hit    = (req_mode > CAP_ABOVE) && ((ultra_raw & FAST_BITS) != '0) && !cable80;
  assign mask_ultra = cap_hit ? (ultra_raw & SAFE_KEEP) : ultra_raw;

  assign mask_mword = id_valid_bits[1] ? (host_mword_mask & id_mword[MASK_W-1:0]) : '0;

  always_comb begin
    if (id_valid_bits[1])
      mask_sword = host_sword_mask & id_sword[MASK_W-1:0];
    else
      mask_sword = legacy_mask(id_legacy_tm, host_sword_mask);
  end
endmodule

// File: rtl/xms_id_check.sv
module xms_id_check
  import xms_pkg::*;
(
  input  logic [2:1]      id_valid_bits,
  input  logic [ID_W-1:0] id_ultra,
  input  logic [ID_W-1:0] id_mword,
  input  logic [ID_W-1:0] id_sword,
  output logic            id_bad
);
  logic u_sel, m_sel, s_sel;

  assign u_sel = |id_ultra[ID_W-1:MASK_W];
  assign m_sel = |id_mword[ID_W-1:MASK_W];
  assign s_sel = |id_sword[ID_W-1:MASK_W];

  always_comb begin
    if (id_valid_bits[2])      id_bad = u_sel && m_sel;
    else if (id_valid_bits[1]) id_bad = m_sel && s_sel;
    else                       id_bad = 1'b0;
  end
endmodule

// File: rtl/xms_pick.sv
module xms_pick
  import xms_pkg::*;
(
  input  logic [FAM_N-1:0][MASK_W-1:0] fam_mask,  // index 0 = highest priority
  input  logic [FAM_N-1:0][CODE_W-1:0] fam_base,
  input  code_t                        req_mode,
  output code_t                        sel_code,
  output logic [FAM_N-1:0]             fam_ok
);
  code_t fam_code [FAM_N];

  for (genvar f = 0; f < FAM_N; f++) begin : g_fam
    logic [IDX_W:0] tb;
    assign tb          = top_bit(fam_mask[f]);
    assign fam_ok[f]   = (req_mode >= fam_base[f]) && tb[IDX_W];
    assign fam_code[f] = fam_base[f] + code_t'(tb[IDX_W-1:0]);
  end

  always_comb begin
    sel_code = NO_MODE;
    for (int f = FAM_N - 1; f >= 0; f--)
      if (fam_ok[f]) sel_code = fam_code[f];
  end
endmodule

// File: rtl/xfer_mode_sel.sv
module xfer_mode_sel
  import xms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              compute,
  input  logic [CODE_W-1:0] req_mode,
  input  logic [2:1]        id_valid_bits,
  input  logic [ID_W-1:0]   id_ultra,
  input  logic [ID_W-1:0]   id_mword,
  input  logic [ID_W-1:0]   id_sword,
  input  logic [ID_W-1:0]   id_legacy_tm,
  input  logic [MASK_W-1:0] host_ultra_mask,
  input  logic [MASK_W-1:0] host_mword_mask,
  input  logic [MASK_W-1:0] host_sword_mask,
  input  logic              cable80,
  input  logic              is_disk,
  input  logic              host_no_pkt_dma,
  output logic [CODE_W-1:0] mode,
  output logic              no_dma,
  output logic              valid
);
  mask_t            mask_ultra, mask_mword, mask_sword;
  logic             cap_hit, id_bad, pkt_block;
  code_t            sel_code, next_code;
  logic [FAM_N-1:0] fam_ok;
  logic [FAM_N-1:0][MASK_W-1:0] fam_mask;
  logic [FAM_N-1:0][CODE_W-1:0] fam_base;

  xms_family_masks u_masks (
    .id_valid_bits   (id_valid_bits),
    .id_ultra        (id_ultra),
    .id_mword        (id_mword),
    .id_sword        (id_sword),
    .id_legacy_tm    (id_legacy_tm),
    .host_ultra_mask (host_ultra_mask),
    .host_mword_mask (host_mword_mask),
    .host_sword_mask (host_sword_mask),
    .cable80         (cable80),
    .req_mode        (req_mode),
    .mask_ultra      (mask_ultra),
    .mask_mword      (mask_mword),
    .mask_sword      (mask_sword),
    .cap_hit         (cap_hit)
  );

  xms_id_check u_idchk (
    .id_valid_bits (id_valid_bits),
    .id_ultra      (id_ultra),
    .id_mword      (id_mword),
    .id_sword      (id_sword),
    .id_bad        (id_bad)
  );

  assign fam_mask = {mask_sword, mask_mword, mask_ultra};
  assign fam_base = {SW_BASE, MW_BASE, UD_BASE};

  xms_pick u_pick (
    .fam_mask (fam_mask),
    .fam_base (fam_base),
    .req_mode (req_mode),
    .sel_code (sel_code),
    .fam_ok   (fam_ok)
  );

  assign pkt_block = !is_disk && host_no_pkt_dma;
  assign next_code = (pkt_block || id_bad) ? NO_MODE : code_min(sel_code, req_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= NO_MODE;
      no_dma <= 1'b1;
      valid  <= 1'b0;
    end else begin
      valid <= compute;
      if (compute) begin
        mode   <= next_code;
        no_dma <= (next_code == NO_MODE);
      end
    end
  end
endmodule

// File: rtl/xms_chk.sv
module xms_chk
  import xms_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        compute,
  input code_t       req_mode,
  input logic        is_disk,
  input logic        host_no_pkt_dma,
  input code_t       mode,
  input logic        no_dma,
  input logic        valid,
  input logic        id_bad,
  input logic        cap_hit
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compute |=> valid);
  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !compute |=> !valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !compute |=> ($stable(mode) && $stable(no_dma)));
  // R8
  req_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compute |=> (mode <= $past(req_mode)));
  // R8
  nodma_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (no_dma == (mode == NO_MODE)));
  // R9
  pkt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compute && !is_disk && host_no_pkt_dma) |=> no_dma);
  // R10
  id_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compute && id_bad) |=> (no_dma && mode == NO_MODE));
  // R5
  cable_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compute && cap_hit) |=> !(mode > 8'h42 && mode < 8'h47));
endmodule

bind xfer_mode_sel xms_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .compute         (compute),
  .req_mode        (req_mode),
  .is_disk         (is_disk),
  .host_no_pkt_dma (host_no_pkt_dma),
  .mode            (mode),
  .no_dma          (no_dma),
  .valid           (valid),
  .id_bad          (id_bad),
  .cap_hit         (cap_hit)
);

// File: tb/tb_xfer_mode_sel.sv
`timescale 1ns/1ps
module tb_xfer_mode_sel;
  logic clk = 1'b0, rst_n = 1'b0, compute = 1'b0;
  logic [7:0]  req_mode = '0;
  logic [2:1]  fv = '0;
  logic [15:0] du = '0, dm = '0, ds = '0, leg = '0;
  logic [7:0]  hu = '0, hm = '0, hs = '0;
  logic cable = 1'b0, disk = 1'b1, nopkt = 1'b0;
  logic [7:0] mode;
  logic no_dma, valid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xfer_mode_sel dut (
    .clk(clk), .rst_n(rst_n), .compute(compute), .req_mode(req_mode),
    .id_valid_bits(fv), .id_ultra(du), .id_mword(dm), .id_sword(ds),
    .id_legacy_tm(leg), .host_ultra_mask(hu), .host_mword_mask(hm),
    .host_sword_mask(hs), .cable80(cable), .is_disk(disk),
    .host_no_pkt_dma(nopkt), .mode(mode), .no_dma(no_dma), .valid(valid)
  );

  logic [7:0] reqs [16] = '{8'h00, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h1F, 8'h20, 8'h21,
                            8'h22, 8'h3F, 8'h40, 8'h42, 8'h43, 8'h45, 8'h47, 8'hFF};

  function automatic logic [7:0] expect_mode();
    logic [7:0] um, mm, sm, best;
    logic bad;
    if (!disk && nopkt) return 8'h00;
    bad = 1'b0;
    if (fv[2])      bad = (du[15:8] != 0) && (dm[15:8] != 0);
    else if (fv[1]) bad = (dm[15:8] != 0) && (ds[15:8] != 0);
    if (bad) return 8'h00;
    um = fv[2] ? (du[7:0] & hu) : 8'h00;
    if (req_mode > 8'h42 && (um & 8'h78) != 0 && !cable) um = um & 8'h07;
    mm = fv[1] ? (dm[7:0] & hm) : 8'h00;
    sm = 8'h00;
    if (fv[1]) sm = ds[7:0] & hs;
    else if (leg != 0 && leg[7:0] <= 2) begin
      for (int k = 0; k <= int'(leg[7:0]); k++) sm[k] = 1'b1;
      sm = sm & hs;
    end
    best = 8'h00;
    if (req_mode >= 8'h40) for (int k = 0; k < 8; k++) if (um[k]) best = 8'h40 + 8'(k);
    if (best == 0 && req_mode >= 8'h20) for (int k = 0; k < 8; k++) if (mm[k]) best = 8'h20 + 8'(k);
    if (best == 0 && req_mode >= 8'h10) for (int k = 0; k < 8; k++) if (sm[k]) best = 8'h10 + 8'(k);
    return (best < req_mode) ? best : req_mode;
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // inputs already set; strobe and check the captured result
  task automatic run_case(input string tag);
    logic [7:0] e;
    e = expect_mode();
    @(negedge clk) compute = 1'b1;
    @(negedge clk) compute = 1'b0;
    check({tag, " R8 mode/no_dma"}, {mode, no_dma}, {e, (e == 8'h00)});
    check("R2 valid pulse", {8'h00, valid}, 9'h001);
  endtask

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    logic [15:0] legs [7] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0100, 16'h0102, 16'h00FF};
    logic [7:0]  dus [5]  = '{8'h00, 8'h07, 8'h3F, 8'h80, 8'hFF};
    logic [7:0]  dms [3]  = '{8'h00, 8'h01, 8'h07};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {mode, no_dma}, 9'h001);
    check("R1 reset valid", {8'h00, valid}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6: family priority, gating and cable cap
    hm = 8'h07; hs = 8'h07;
    for (int a = 0; a < 4; a++)
      for (int h = 0; h < 2; h++)
        for (int u = 0; u < 5; u++)
          for (int m = 0; m < 3; m++)
            for (int s = 0; s < 2; s++)
              for (int c = 0; c < 2; c++)
                for (int r = 0; r < 16; r++) begin
                  fv = 2'(a); hu = h ? 8'h1F : 8'hFF;
                  du = {8'h00, dus[u]}; dm = {8'h00, dms[m]};
                  ds = {8'h00, s ? 8'h03 : 8'h00};
                  cable = c[0]; req_mode = reqs[r]; leg = 16'h0000;
                  run_case((fv[2] && !cable && req_mode > 8'h42) ? "R5 cap" : "R3 R4 R6 search");
                end

    // R7: singleword via identify word or legacy timing word
    du = '0; dm = 16'h0000; hu = 8'hFF; hm = 8'h00; ds = 16'h0005;
    for (int a = 0; a < 2; a++)
      for (int l = 0; l < 7; l++)
        for (int h = 0; h < 8; h++)
          for (int r = 0; r < 16; r++) begin
            fv = a ? 2'b01 : 2'b00; leg = legs[l]; hs = 8'(h); req_mode = reqs[r];
            run_case("R7 singleword");
          end

    // R10: inconsistent identify data
    hu = 8'hFF; hm = 8'hFF; hs = 8'hFF; leg = 16'h0000; req_mode = 8'hFF; cable = 1'b1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 8; b++) begin
        fv = 2'(a);
        du = {b[0] ? 8'h04 : 8'h00, 8'h7F};
        dm = {b[1] ? 8'h04 : 8'h00, 8'h07};
        ds = {b[2] ? 8'h04 : 8'h00, 8'h07};
        run_case("R10 id check");
      end

    // R9: packet device on a host without packet DMA
    fv = 2'b11; du = 16'h007F; dm = 16'h0007; ds = 16'h0007;
    for (int d = 0; d < 2; d++)
      for (int n = 0; n < 2; n++) begin
        disk = d[0]; nopkt = n[0];
        run_case("R9 packet block");
      end
    disk = 1'b1; nopkt = 1'b0;

    // R2: outputs hold without a strobe
    run_case("R2 setup");
    held = mode;
    @(negedge clk);
    req_mode = 8'h00; fv = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 hold mode", {mode, no_dma}, {held, 1'b0});
    check("R2 no valid", {8'h00, valid}, 9'h000);

    finish_run();
  end
endmodule